// File: doc/BRIEF.md
# Strobe-Windowed 1-of-8 Decoder

This block turns a 3-bit select code into one of eight active-high select lines. A line is driven only inside a time window that two processor timing strobes define. The window opens when strobe A goes from high to low and closes when strobe B goes from high to low. A chip-enable input qualifies the window.

Both strobes reach the block from outside the clock domain. Each one passes through a two-stage synchronizer, and its falling edge is found by comparing consecutive samples. The select code and chip enable are taken on the clock edge where a strobe-A fall is seen. The chosen line therefore stays fixed for the whole window, even if the code lines move. Several decoders can share the same code and strobe wires and be told apart by their chip enables. This gives multi-level decoding. The block decodes all eight codes. Keeping code 0 unused for device selection is a system convention.

Top module: `strobe_window_decoder`

## Requirements
- R1: A synchronous active-high reset closes the window and drives all eight select lines low. They stay low on the first cycle after reset is released.
- R2: While the window is open, exactly the line whose index equals the captured code is high (code c drives bit c of the output). At no time is more than one line high.
- R3: Strobe A may be sampled high at rising clock edge k-1 and low at edge k. In that case, from edge k+2 the line selected by the code present at edge k+2 is high, provided chip enable is high at that edge.
- R4: Strobe B may be sampled high at edge k-1 and low at edge k while the window is open. In that case the window stays open through edge k+1, and all lines are low from edge k+2.
- R5: Chip enable may be sampled low at a clock edge. All lines are then low after that edge, and the window is cancelled: it stays closed after chip enable returns high, until the next strobe-A fall.
- R6: Changes on the select code while the window is open do not change the driven line.
- R7: A strobe-B fall with no open window has no effect: all lines stay low.
- R8: A second strobe-A fall before strobe B falls restarts the window with the newly captured code.
- R9: A strobe-A fall and a strobe-B fall detected on the same clock edge open the window. Strobe A takes priority.
- R10: A strobe-A fall seen while chip enable is low leaves the window closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| selCode | input | 3 | Select code, captured at the start of the window |
| strobeA | input | 1 | Timing strobe whose falling edge opens the window |
| strobeB | input | 1 | Timing strobe whose falling edge closes the window |
| chipEn | input | 1 | Active-high enable; low forces all lines low |
| selOut | output | 8 | One-hot select lines, active high |

## Verification
The assertions assume that chip enable and the select code are synchronous to the system clock. Only the two strobes are treated as asynchronous, and the checker finds their falls with its own sample chain of the same depth. The stimulus changes every input only on the falling clock edge, so each value is seen cleanly at the next rising edge. Each strobe is held low for at least one full clock before it returns high, so the synchronizers always see every fall.

// File: rtl/swd_pkg.sv
`timescale 1ns/1ps
package swd_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic loadCode;   // capture code on this cycle
    logic windowOn;   // window currently open
  } ctrlStrobes_t;
endpackage

// File: rtl/swd_edge_sync.sv
`timescale 1ns/1ps
module swd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fallPulse
);
  logic [STAGES-1:0] chain;
  logic              lastSample;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain      <= '0;
      lastSample <= 1'b0;
    end else begin
      chain      <= {chain[STAGES-2:0], din};
      lastSample <= chain[STAGES-1];
    end
  end

  // previous synchronized sample high, current one low
  assign fallPulse = lastSample & ~chain[STAGES-1];
endmodule

// File: rtl/swd_control.sv
`timescale 1ns/1ps
module swd_control
  import swd_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         fallA,
  input  logic         fallB,
  input  logic         chipEn,
  output ctrlStrobes_t ctrl
);
  logic windowOn;

  always_ff @(posedge clk) begin
    if (rst) begin
      windowOn <= 1'b0;
    end else if (fallA) begin
      // strobe A wins over a coincident strobe B
      windowOn <= chipEn;
    end else if (fallB || !chipEn) begin
      windowOn <= 1'b0;
    end
  end

  always_comb begin
    ctrl.loadCode = fallA;
    ctrl.windowOn = windowOn;
  end
endmodule

// File: rtl/swd_datapath.sv
`timescale 1ns/1ps
module swd_datapath
  import swd_pkg::*;
#(
  parameter  int CODE_WIDTH = 3,
  localparam int OUT_COUNT  = 1 << CODE_WIDTH
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CODE_WIDTH-1:0] selCode,
  input  ctrlStrobes_t          ctrl,
  output logic [OUT_COUNT-1:0]  selOut
);
  logic [CODE_WIDTH-1:0] codeReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      codeReg <= '0;
    end else if (ctrl.loadCode) begin
      codeReg <= selCode;
    end
  end

  for (genvar i = 0; i < OUT_COUNT; i++) begin : g_line
    assign selOut[i] = ctrl.windowOn && (codeReg == CODE_WIDTH'(i));
  end
endmodule

// File: rtl/strobe_window_decoder.sv
`timescale 1ns/1ps
module strobe_window_decoder
  import swd_pkg::*;
#(
  parameter  int CODE_WIDTH  = 3,
  parameter  int SYNC_STAGES = 2,
  localparam int OUT_COUNT   = 1 << CODE_WIDTH
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CODE_WIDTH-1:0] selCode,
  input  logic                  strobeA,
  input  logic                  strobeB,
  input  logic                  chipEn,
  output logic [OUT_COUNT-1:0]  selOut
);
  localparam int NUM_STROBES = 2;

  logic [NUM_STROBES-1:0] strobeIn;
  logic [NUM_STROBES-1:0] strobeFall;
  ctrlStrobes_t           ctrl;

  assign strobeIn = {strobeB, strobeA};

  for (genvar s = 0; s < NUM_STROBES; s++) begin : g_sync
    swd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst       (rst),
      .din       (strobeIn[s]),
      .fallPulse (strobeFall[s])
    );
  end

  swd_control u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .fallA  (strobeFall[0]),
    .fallB  (strobeFall[1]),
    .chipEn (chipEn),
    .ctrl   (ctrl)
  );

  swd_datapath #(.CODE_WIDTH(CODE_WIDTH)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .selCode (selCode),
    .ctrl    (ctrl),
    .selOut  (selOut)
  );
endmodule

// File: rtl/swd_checker.sv
`timescale 1ns/1ps
module swd_checker #(
  parameter  int CODE_WIDTH  = 3,
  parameter  int SYNC_STAGES = 2,
  localparam int OUT_COUNT   = 1 << CODE_WIDTH
) (
  input logic                  clk,
  input logic                  rst,
  input logic [CODE_WIDTH-1:0] selCode,
  input logic                  strobeA,
  input logic                  strobeB,
  input logic                  chipEn,
  input logic [OUT_COUNT-1:0]  selOut
);
  // independent sample history of each strobe
  logic [SYNC_STAGES:0] histA;
  logic [SYNC_STAGES:0] histB;
  logic aFall;
  logic bFall;

  always_ff @(posedge clk) begin
    if (rst) begin
      histA <= '0;
      histB <= '0;
    end else begin
      histA <= {histA[SYNC_STAGES-1:0], strobeA};
      histB <= {histB[SYNC_STAGES-1:0], strobeB};
    end
  end

  assign aFall = histA[SYNC_STAGES] & ~histA[SYNC_STAGES-1];
  assign bFall = histB[SYNC_STAGES] & ~histB[SYNC_STAGES-1];

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (selOut == '0));

  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(selOut));

  // also covers R9 (A has priority) and R8 (restart takes new code)
  assert_open_R3: assert property (@(posedge clk) disable iff (rst)
    (aFall && chipEn) |=> (selOut == (OUT_COUNT'(1) << $past(selCode))));

  assert_close_R4: assert property (@(posedge clk) disable iff (rst)
    (bFall && !aFall) |=> (selOut == '0));

  assert_enable_low_R5: assert property (@(posedge clk) disable iff (rst)
    !chipEn |=> (selOut == '0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ((selOut != '0) && !aFall && !bFall && chipEn) |=> $stable(selOut));

  assert_stay_closed_R7: assert property (@(posedge clk) disable iff (rst)
    ((selOut == '0) && !aFall) |=> (selOut == '0));
endmodule

bind strobe_window_decoder swd_checker #(
  .CODE_WIDTH  (CODE_WIDTH),
  .SYNC_STAGES (SYNC_STAGES)
) i_checker (.*);

// File: tb/test_strobe_window_decoder.sv
`timescale 1ns/1ps
module test_strobe_window_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] selCode = 3'd0;
  logic       strobeA = 1'b1;
  logic       strobeB = 1'b1;
  logic       chipEn = 1'b1;
  logic [7:0] selOut;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  strobe_window_decoder i_strobe_window_decoder (
    .clk(clk), .rst(rst), .selCode(selCode), .strobeA(strobeA),
    .strobeB(strobeB), .chipEn(chipEn), .selOut(selOut)
  );

  // behavioural reference: sample queues plus window state
  bit qa[$] = '{0, 0, 0};
  bit qb[$] = '{0, 0, 0};
  bit mOpen = 1'b0;
  int mCode = 0;

  always @(posedge clk) begin
    bit fA, fB;
    if (rst) begin
      mOpen = 1'b0; mCode = 0;
      qa = '{0, 0, 0}; qb = '{0, 0, 0};
    end else begin
      fA = qa[2] && !qa[1];
      fB = qb[2] && !qb[1];
      if (fA) begin
        mOpen = chipEn; mCode = int'(selCode);
      end else if (fB || !chipEn) begin
        mOpen = 1'b0;
      end
      qa.push_front(strobeA); void'(qa.pop_back());
      qb.push_front(strobeB); void'(qb.pop_back());
    end
  end

  function automatic logic [7:0] modelOut();
    return mOpen ? (8'b1 << mCode) : 8'h00;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (selOut !== modelOut()) begin
        errors++;
        $display("FAIL %s (model): actual %h expected %h at %0t",
                 curReq, selOut, modelOut(), $time);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectOut(input logic [7:0] exp, input string tag);
    checks++;
    if (selOut !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, selOut, exp, $time);
    end
  endtask

  // drive a strobe-A pulse; returns three negedges after the fall
  task automatic pulseA(input logic [2:0] code);
    selCode = code; strobeA = 1'b0;
    tick(1); strobeA = 1'b1;
    tick(2);
  endtask

  task automatic closeB();
    strobeB = 1'b0;
    tick(1); strobeB = 1'b1;
    tick(2);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    curReq = "R1";
    expectOut(8'h00, "R1 during reset");
    rst = 1'b0;
    tick(1);
    expectOut(8'h00, "R1 after release");

    // R2/R3/R4/R6: every code, hold, close timing
    for (int c = 0; c < 8; c++) begin
      curReq = "R3";
      pulseA(3'(c));
      expectOut(8'b1 << c, "R2 R3 decode");
      curReq = "R6";
      selCode = 3'(c + 3);
      tick(2);
      expectOut(8'b1 << c, "R6 hold");
      curReq = "R4";
      strobeB = 1'b0;
      tick(1); strobeB = 1'b1;
      tick(1);
      expectOut(8'b1 << c, "R4 still open");
      tick(1);
      expectOut(8'h00, "R4 closed");
      tick(2);
    end

    curReq = "R7";
    closeB();
    tick(2);
    expectOut(8'h00, "R7 stray B");

    curReq = "R8";
    pulseA(3'd2);
    expectOut(8'h04, "R8 first window");
    pulseA(3'd5);
    expectOut(8'h20, "R8 restart");
    closeB();
    expectOut(8'h00, "R8 closed");

    curReq = "R5";
    pulseA(3'd3);
    expectOut(8'h08, "R5 open");
    chipEn = 1'b0;
    tick(1);
    expectOut(8'h00, "R5 enable low");
    chipEn = 1'b1;
    tick(3);
    expectOut(8'h00, "R5 cancelled");

    curReq = "R10";
    chipEn = 1'b0;
    pulseA(3'd4);
    chipEn = 1'b1;
    tick(2);
    expectOut(8'h00, "R10 disabled at A");

    curReq = "R9";
    selCode = 3'd6; strobeA = 1'b0; strobeB = 1'b0;
    tick(1); strobeA = 1'b1; strobeB = 1'b1;
    tick(2);
    expectOut(8'h40, "R9 A priority");
    closeB();
    expectOut(8'h00, "R9 closed");

    curReq = "R1";
    pulseA(3'd7);
    rst = 1'b1;
    tick(1);
    expectOut(8'h00, "R1 reset mid-window");
    rst = 1'b0;
    tick(3);
    expectOut(8'h00, "R1 stays clear");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule